// File: doc/BRIEF.md
# Token Rotation Timing Unit

This unit keeps the timed-token clocks of one station on a token ring. A rotation timer counts down from the negotiated target rotation time. Each token arrival reloads it. If it reaches zero before a token comes back, the station marks the token as late. If it reaches zero a second time while the late mark is still set, the unit raises a one-cycle request for ring recovery. A separate valid-transmission timer watches for a silent ring. It is restarted by every valid frame and by every token, and it pulses when it runs out.

When a token arrives early, the time left on the rotation timer moves into a holding timer. That holding time limits asynchronous transmission during this visit of the token. Synchronous service is granted on every arrival, whether early or late. A priority asynchronous class is granted only while the holding time is still larger than a programmable threshold. The threshold, the maximum target time and the valid-transmission time are each held as 4-bit codes. Each code expands to a power-of-two tick count. The negotiated time arrives as a 32-bit two's complement value from the claim process.

Top module: `token_rotation_timer`

## Requirements
- R1: While rst_n is low, all six outputs are 0. On the first clock after reset is released, both timers load their full reload values.
- R2: A neg_load strobe with a negative neg_value sets the target to the magnitude of that value. The new target is used from the next reload on. A strobe with bit 31 clear is ignored. The target is capped at the expanded max_code and at 2^TW-1.
- R3: When the rotation timer is at zero, no token arrives and late_flag is 0, late_flag becomes 1 and the timer reloads to the target. The late mark is therefore set target+1 cycles after the previous reload.
- R4: When the rotation timer reaches zero while late_flag is 1, recover_req is 1 for exactly one cycle. In the same update late_flag clears and the timer reloads. The gap from the rise of late_flag to recover_req is target+1 cycles.
- R5: A token arrival reloads the rotation timer and clears late_flag. It takes precedence over an expiry in the same cycle: no late mark is set and no recovery is requested.
- R6: On an early arrival (late_flag 0), the remaining rotation time is copied into the holding timer, which then counts down to zero. A late arrival loads zero. async_en is 1 while a token is held and the holding time is non-zero.
- R7: sync_en is 1 from the cycle after any token arrival until the cycle after token_release. A token arrival in the same cycle as a release wins.
- R8: async_prio_en is 1 while a token is held, prio_code is non-zero and the holding time is strictly greater than the expanded prio_code.
- R9: A code k from 1 to 15 expands to 2^(k+8) ticks. Code 0 means disabled: with max_code 0 there is no cap, with prio_code 0 the priority class is never granted, and with tvx_code 0 the valid-transmission timer never expires.
- R10: The valid-transmission timer restarts from the expanded tvx_code on frame_valid or token_seen. When it reaches zero with no restart, tvx_expired pulses for one cycle and the timer reloads. A restart in the expiry cycle suppresses the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one timer tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| token_seen | input | 1 | Strobe: a valid token has arrived |
| frame_valid | input | 1 | Strobe: a valid frame was seen on the ring |
| token_release | input | 1 | Strobe: the station has released the token |
| neg_load | input | 1 | Strobe: load the negotiated rotation time |
| neg_value | input | 32 | Negotiated rotation time, two's complement (negative) |
| max_code | input | 4 | Maximum target rotation time code |
| prio_code | input | 4 | Priority asynchronous threshold code |
| tvx_code | input | 4 | Valid-transmission time code |
| late_flag | output | 1 | Token is late for this rotation |
| recover_req | output | 1 | One-cycle ring recovery request |
| tvx_expired | output | 1 | One-cycle valid-transmission timeout |
| sync_en | output | 1 | Synchronous transmission allowed |
| async_en | output | 1 | Asynchronous transmission allowed |
| async_prio_en | output | 1 | Priority asynchronous transmission allowed |

## Verification
Two events can land on the same cycle: a token arrival and the rotation timer reaching zero. The bench uses its own reference count to drive token_seen exactly on the zero cycle, once with the late mark clear and once with it set. It then judges that late_flag stays clear, that recover_req never pulses, and that the following late mark comes a full target+1 cycles later. The same method drives frame_valid on the cycle the valid-transmission timer hits zero, and expects no tvx_expired pulse.

// File: rtl/ttu_pkg.sv
package ttu_pkg;
   localparam int CODE_W    = 4;
   localparam int EXP_BASE  = 8;
   localparam int NEG_W     = 32;
endpackage

// File: rtl/ttu_code_expand.sv
module ttu_code_expand #(
   parameter int CODE_W = 4,
   parameter int TW     = 24,
   parameter int BASE   = 8
) (
   input  logic [CODE_W-1:0] code,
   output logic [TW-1:0]     value
);
   localparam int N = 1 << CODE_W;
   logic [TW-1:0] tbl [N];

   assign tbl[0] = '0;
   for (genvar k = 1; k < N; k++) begin : g_ent
      assign tbl[k] = TW'(1) << (k + BASE);
   end
   assign value = tbl[code];
endmodule

// File: rtl/ttu_rot_timer.sv
module ttu_rot_timer #(
   parameter int TW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          primed,
   input  logic          tok,
   input  logic          rel,
   input  logic [TW-1:0] tgt,
   output logic          late_q,
   output logic          rec_q,
   output logic          hold_q,
   output logic [TW-1:0] tht_q
);
   logic [TW-1:0] trt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trt_q  <= '0;
         tht_q  <= '0;
         late_q <= 1'b0;
         rec_q  <= 1'b0;
         hold_q <= 1'b0;
      end else if (!primed) begin
         trt_q <= tgt;
         rec_q <= 1'b0;
      end else begin
         rec_q <= 1'b0;
         if (tok) begin
            late_q <= 1'b0;
            trt_q  <= tgt;
            tht_q  <= late_q ? '0 : trt_q;
            hold_q <= 1'b1;
         end else begin
            if (rel) hold_q <= 1'b0;
            if (tht_q != '0) tht_q <= tht_q - 1'b1;
            if (trt_q == '0) begin
               trt_q <= tgt;
               if (late_q) begin
                  late_q <= 1'b0;
                  rec_q  <= 1'b1;
               end else begin
                  late_q <= 1'b1;
               end
            end else begin
               trt_q <= trt_q - 1'b1;
            end
         end
      end
   end

   // R3
   late_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(late_q) |-> $past(!tok));
   // R4
   recovery_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_q |-> ($past(late_q) && !late_q) ##1 !rec_q);
   // R5
   token_clears_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(tok && primed) |-> (!late_q && !rec_q && hold_q));
   // R6
   hold_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!(tok && primed)) |-> (tht_q <= $past(tht_q)));
endmodule

// File: rtl/ttu_valid_timer.sv
module ttu_valid_timer #(
   parameter int TW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          primed,
   input  logic          enable,
   input  logic          restart,
   input  logic [TW-1:0] reload,
   output logic          expired_q
);
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         expired_q <= 1'b0;
      end else begin
         expired_q <= 1'b0;
         if (!primed) begin
            cnt_q <= reload;
         end else if (!enable) begin
            cnt_q <= '0;
         end else if (restart) begin
            cnt_q <= reload;
         end else if (cnt_q == '0) begin
            cnt_q     <= reload;
            expired_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   // R9
   tvx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expired_q |-> $past(enable && !restart));
   // R10
   tvx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expired_q |=> !expired_q);
endmodule

// File: rtl/ttu_class_gate.sv
module ttu_class_gate #(
   parameter int TW = 24
) (
   input  logic          hold,
   input  logic [TW-1:0] tht,
   input  logic          prio_on,
   input  logic [TW-1:0] prio_val,
   output logic          sync_en,
   output logic          async_en,
   output logic          prio_en
);
   always_comb begin
      sync_en  = hold;
      async_en = hold && (tht != '0);
      prio_en  = hold && prio_on && (tht > prio_val);
   end
endmodule

// File: rtl/token_rotation_timer.sv
module token_rotation_timer #(
   parameter int TW = 24
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        token_seen,
   input  logic        frame_valid,
   input  logic        token_release,
   input  logic        neg_load,
   input  logic [31:0] neg_value,
   input  logic [3:0]  max_code,
   input  logic [3:0]  prio_code,
   input  logic [3:0]  tvx_code,
   output logic        late_flag,
   output logic        recover_req,
   output logic        tvx_expired,
   output logic        sync_en,
   output logic        async_en,
   output logic        async_prio_en
);
   import ttu_pkg::*;

   localparam int          MIN_TW = (1 << CODE_W) - 1 + EXP_BASE + 1;
   localparam logic [NEG_W-1:0] CAP = NEG_W'((64'(1) << TW) - 1);

   if (TW < MIN_TW || TW > NEG_W) begin : g_bad_width
      $error("token_rotation_timer: TW out of range");
   end

   logic [NEG_W-1:0] mag_q;
   logic             primed_q;
   logic [TW-1:0]    max_val, prio_val, tvx_val, tgt;
   logic [NEG_W-1:0] lim;
   logic             hold;
   logic [TW-1:0]    tht;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mag_q    <= '1;
         primed_q <= 1'b0;
      end else begin
         primed_q <= 1'b1;
         if (neg_load && neg_value[NEG_W-1]) mag_q <= -neg_value;
      end
   end

   ttu_code_expand #(.CODE_W(CODE_W), .TW(TW), .BASE(EXP_BASE)) i_max_exp (
      .code(max_code), .value(max_val));
   ttu_code_expand #(.CODE_W(CODE_W), .TW(TW), .BASE(EXP_BASE)) i_prio_exp (
      .code(prio_code), .value(prio_val));
   ttu_code_expand #(.CODE_W(CODE_W), .TW(TW), .BASE(EXP_BASE)) i_tvx_exp (
      .code(tvx_code), .value(tvx_val));

   always_comb begin
      lim = (max_code != '0) ? NEG_W'(max_val) : CAP;
      tgt = (mag_q > lim) ? TW'(lim) : TW'(mag_q);
   end

   ttu_rot_timer #(.TW(TW)) i_rot (
      .clk(clk), .rst_n(rst_n), .primed(primed_q), .tok(token_seen),
      .rel(token_release), .tgt(tgt), .late_q(late_flag), .rec_q(recover_req),
      .hold_q(hold), .tht_q(tht));

   ttu_valid_timer #(.TW(TW)) i_tvx (
      .clk(clk), .rst_n(rst_n), .primed(primed_q), .enable(tvx_code != '0),
      .restart(frame_valid || token_seen), .reload(tvx_val),
      .expired_q(tvx_expired));

   ttu_class_gate #(.TW(TW)) i_gate (
      .hold(hold), .tht(tht), .prio_on(prio_code != '0), .prio_val(prio_val),
      .sync_en(sync_en), .async_en(async_en), .prio_en(async_prio_en));

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> !(late_flag || recover_req || tvx_expired || sync_en));
   // R8
   prio_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      async_prio_en |-> (async_en && prio_code != '0));
endmodule

// File: tb/test_token_rotation_timer.sv
module test_token_rotation_timer;
   localparam int TW = 24;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic token_seen = 0, frame_valid = 0, token_release = 0, neg_load = 0;
   logic [31:0] neg_value = '0;
   logic [3:0] max_code = '0, prio_code = '0, tvx_code = '0;
   logic late_flag, recover_req, tvx_expired, sync_en, async_en, async_prio_en;
   int checks = 0, errors = 0;

   always #5 clk = ~clk;

   token_rotation_timer #(.TW(TW)) i_token_rotation_timer (.*);

   // reference model
   logic        m_primed, m_late, m_rec, m_hold, m_tvxp;
   logic [31:0] m_mag, m_trt, m_tht, m_tvx;

   function automatic logic [31:0] expand(logic [3:0] k);
      return (k == 0) ? 32'd0 : (32'd1 << (k + 8));
   endfunction

   function automatic logic [31:0] target_of(logic [31:0] mag, logic [3:0] mc);
      logic [31:0] lim;
      lim = (mc != 0) ? expand(mc) : ((32'd1 << TW) - 1);
      return (mag > lim) ? lim : mag;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_primed <= 0; m_late <= 0; m_rec <= 0; m_hold <= 0; m_tvxp <= 0;
         m_mag <= '1; m_trt <= 0; m_tht <= 0; m_tvx <= 0;
      end else begin
         m_primed <= 1;
         if (neg_load && neg_value[31]) m_mag <= 32'd0 - neg_value;
         m_rec  <= 0;
         m_tvxp <= 0;
         if (!m_primed) begin
            m_trt <= target_of(m_mag, max_code);
            m_tvx <= expand(tvx_code);
         end else begin
            if (token_seen) begin
               m_late <= 0; m_hold <= 1;
               m_trt <= target_of(m_mag, max_code);
               m_tht <= m_late ? 0 : m_trt;
            end else begin
               if (token_release) m_hold <= 0;
               if (m_tht != 0) m_tht <= m_tht - 1;
               if (m_trt == 0) begin
                  m_trt <= target_of(m_mag, max_code);
                  if (m_late) begin m_late <= 0; m_rec <= 1; end
                  else m_late <= 1;
               end else m_trt <= m_trt - 1;
            end
            if (tvx_code == 0) m_tvx <= 0;
            else if (frame_valid || token_seen) m_tvx <= expand(tvx_code);
            else if (m_tvx == 0) begin m_tvx <= expand(tvx_code); m_tvxp <= 1; end
            else m_tvx <= m_tvx - 1;
         end
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("R3 late_flag", late_flag, m_late);
      chk("R4 recover_req", recover_req, m_rec);
      chk("R10 tvx_expired", tvx_expired, m_tvxp);
      chk("R7 sync_en", sync_en, m_hold);
      chk("R6 async_en", async_en, m_hold && m_tht != 0);
      chk("R8 async_prio_en", async_prio_en,
          m_hold && prio_code != 0 && m_tht > expand(prio_code));
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      compare_all();
   endtask

   task automatic load_neg(logic [31:0] v);
      neg_load = 1; neg_value = v; cyc(); neg_load = 0;
   endtask

   // counts cycles from a fresh rise of late_flag to the recovery pulse
   task automatic gap_check(string tag, int exp);
      int n = 0;
      while (late_flag) cyc();
      while (!late_flag) cyc();
      while (!recover_req && n < 5000) begin cyc(); n++; end
      chk(tag, n, exp);
   endtask

   initial begin
      #(150000 * 10);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 outputs in reset",
          {late_flag, recover_req, tvx_expired, sync_en, async_en, async_prio_en}, 0);
      rst_n = 1;
      max_code = 1; tvx_code = 1;
      cyc();
      load_neg(-32'sd300);
      gap_check("R2 gap for target 300", 301);
      load_neg(32'd50);
      gap_check("R2 positive load ignored", 301);
      load_neg(-32'sd100000);
      gap_check("R2 R9 capped at code 1", 513);
      max_code = 0;
      load_neg(-32'sd700);
      gap_check("R9 max code 0 no cap", 701);
      max_code = 1;
      load_neg(-32'sd300);
      // R5: token on the expiry cycle with late clear
      while (late_flag) cyc();
      while (!(m_trt == 0 && !m_late)) cyc();
      token_seen = 1; cyc(); token_seen = 0;
      chk("R5 coincident early token late", late_flag, 0);
      chk("R7 sync after token", sync_en, 1);
      token_release = 1; cyc(); token_release = 0;
      chk("R7 release", sync_en, 0);
      // R5: token on the expiry cycle with late set
      while (!(m_trt == 0 && m_late)) cyc();
      token_seen = 1; cyc(); token_seen = 0;
      chk("R5 coincident late token no recovery", recover_req, 0);
      chk("R5 coincident late token clears", late_flag, 0);
      chk("R6 late token no async", async_en, 0);
      token_release = 1; cyc(); token_release = 0;
      // R10: frame exactly at valid timer zero
      while (m_tvx != 0) cyc();
      frame_valid = 1; cyc(); frame_valid = 0;
      chk("R10 restart suppresses pulse", tvx_expired, 0);
      // R9: tvx code 0 never expires
      tvx_code = 0;
      begin
         int seen = 0;
         repeat (1200) begin cyc(); if (tvx_expired) seen++; end
         chk("R9 tvx disabled", seen, 0);
      end
      tvx_code = 1;
      // R8 early token with prio code 0 and 1
      max_code = 2; load_neg(-32'sd900);
      while (!late_flag) cyc();
      token_seen = 1; cyc(); token_seen = 0;   // late token, clears late
      prio_code = 0;
      repeat (50) cyc();
      token_seen = 1; cyc(); token_seen = 0;   // early, about 850 left
      chk("R6 early token async", async_en, 1);
      chk("R9 prio code 0 off", async_prio_en, 0);
      prio_code = 1; cyc();
      chk("R8 prio above threshold", async_prio_en, 1);
      token_release = 1; cyc(); token_release = 0;
      // random phase
      for (int i = 0; i < 40000; i++) begin
         token_seen    = ($urandom % 400) == 0;
         token_release = ($urandom % 50) == 0;
         frame_valid   = ($urandom % 300) == 0;
         if (($urandom % 2000) == 0) prio_code = 4'($urandom % 3);
         cyc();
      end
      token_seen = 0; token_release = 0; frame_valid = 0;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule